// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block decodes the control pins of a synchronous burst SRAM once per clock and decides what the memory does on that edge. Three chip selects, a processor-side address strobe, a controller-side address strobe, a burst-step input, an all-lanes write enable, a byte-write enable with four lane enables, a sleep input and an output enable together pick one of eight cycle kinds. The cycle kinds are deselect, begin read, begin write, continue read or write, suspend read or write, and sleep. For each cycle the block also chooses where the address comes from: the external pins, the next burst address or the current burst address.

Bursts step through four words in either a linear or an interleaved order, chosen by a mode input. Writes are gated per 8-bit lane. Read data is registered and appears one clock after the address is taken. The output-enable pin gates the data outputs without waiting for a clock. A small internal array stands in for the memory core, so that the decode, burst and lane behaviour can all be seen at the data port.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The part is selected only when sel1_n=0, sel2=1 and sel3_n=0. A processor strobe (cpu_stb_n=0) with the part selected gives cyc_kind=1 (begin read) and addr_src=1 (external), with lane_wr=0 whatever the write inputs are.
- R2: With sel1_n=1 the processor strobe is ignored. A controller strobe (ctl_stb_n=0) while the part is not selected gives cyc_kind=0 (deselect) and addr_src=0 (none). A processor strobe while sel1_n=0 but sel2=0 or sel3_n=1 also gives a deselect.
- R3: A controller strobe with the part selected and no effective processor strobe gives cyc_kind=2 (begin write) with addr_src=1 when a write is requested. Otherwise it gives cyc_kind=1.
- R4: A write is requested when wr_all_n=0, or when byte_wr_n=0 and at least one lane_en_n bit is 0. On a write cycle, wr_all_n=0 sets lane_wr=4'hF. Otherwise lane_wr[i] is set where lane_en_n[i]=0, and lane i is data bits [8i+7:8i].
- R5: A cycle with neither strobe effective, during a live burst, is a continue when burst_step_n=0: cyc_kind=3 (read) or 4 (write), addr_src=2 (next). It is a suspend when burst_step_n=1: cyc_kind=5 (read) or 6 (write), addr_src=3 (current). The direction follows the write request.
- R6: The burst address keeps the upper bits of the start address. Its low two bits are start+k mod 4 when linear_mode=1, and start XOR k when linear_mode=0, for step k.
- R7: After reset or a deselect no burst is live. Cycles with neither strobe effective are then deselects, with no write and no read.
- R8: A write request on the cycle after a processor-strobe read, with burst_step_n=1, writes the address that the read used.
- R9: Read data appears on dq_out, with dq_oe=1, in the cycle after the read cycle's clock edge, provided out_en_n=0 and sleep=0.
- R10: out_en_n acts without a clock. While out_en_n=1, dq_oe=0 and dq_out=0.
- R11: sleep=1 gives cyc_kind=7 with addr_src=0, lane_wr=0 and dq_oe=0. It leaves the array and the burst position unchanged.
- R12: dq_oe is 0 after reset and in the cycle after any write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel1_n | input | 1 | Chip select 1, active low, also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| burst_step_n | input | 1 | Low advances the burst, high holds it |
| wr_all_n | input | 1 | All-lanes write enable, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| sleep | input | 1 | Sleep override |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | External address |
| wdata | input | 4*LANE_W | Write data |
| dq_out | output | 4*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | Data output drive enable |
| cyc_kind | output | 3 | Decoded cycle kind (codes as in R1 to R11) |
| addr_src | output | 2 | Address source: 0 none, 1 external, 2 next, 3 current |
| lane_wr | output | 4 | Per-lane write strobes for this cycle |

## Verification
The properties assume that every input is stable and known from one falling clock edge through the next rising edge. The only exception is out_en_n, whose effect on dq_oe is checked combinationally at any time. They also assume that the inputs are in a defined idle state before reset is released. The bench changes every input only just after a falling edge, holds the selects and strobes at known levels from time zero, and moves out_en_n mid-cycle only in the scenario that tests its asynchronous action.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_RD_BEGIN = 3'd1,
    CYC_WR_BEGIN = 3'd2,
    CYC_RD_CONT  = 3'd3,
    CYC_WR_CONT  = 3'd4,
    CYC_RD_SUSP  = 3'd5,
    CYC_WR_SUSP  = 3'd6,
    CYC_SLEEP    = 3'd7
  } cyc_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_NEXT = 2'd2,
    SRC_CUR  = 2'd3
  } src_t;

  // write request: all-lanes enable, or byte enable with any lane picked
  function automatic logic write_req(logic all_n, logic byte_n,
                                     logic [LANES-1:0] lane_n);
    return !all_n || (!byte_n && (lane_n != {LANES{1'b1}}));
  endfunction

  function automatic logic [LANES-1:0] lane_mask(logic all_n, logic byte_n,
                                                 logic [LANES-1:0] lane_n);
    if (!all_n) return {LANES{1'b1}};
    if (!byte_n) return ~lane_n;
    return '0;
  endfunction

  // low two address bits of burst step k from start s
  function automatic logic [1:0] burst_low(logic [1:0] s, logic [1:0] k,
                                           logic linear);
    return linear ? (s + k) : (s ^ k);
  endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
(
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             burst_step_n,
  input  logic             wr_all_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             sleep,
  input  logic             burst_live,
  output cyc_t             kind,
  output src_t             src,
  output logic [LANES-1:0] lane_wr,
  output logic             rd_cyc,
  output logic             wr_cyc
);
  logic sel, cpu_eff, wreq;

  assign sel     = !sel1_n && sel2 && !sel3_n;
  assign cpu_eff = !cpu_stb_n && !sel1_n;
  assign wreq    = write_req(wr_all_n, byte_wr_n, lane_en_n);

  always_comb begin
    kind = CYC_DESEL;
    src  = SRC_NONE;
    if (sleep) begin
      kind = CYC_SLEEP;
    end else if (cpu_eff) begin
      if (sel) begin
        kind = CYC_RD_BEGIN;
        src  = SRC_EXT;
      end
    end else if (!ctl_stb_n) begin
      if (sel) begin
        kind = wreq ? CYC_WR_BEGIN : CYC_RD_BEGIN;
        src  = SRC_EXT;
      end
    end else if (burst_live) begin
      if (!burst_step_n) begin
        kind = wreq ? CYC_WR_CONT : CYC_RD_CONT;
        src  = SRC_NEXT;
      end else begin
        kind = wreq ? CYC_WR_SUSP : CYC_RD_SUSP;
        src  = SRC_CUR;
      end
    end
  end

  assign wr_cyc  = (kind == CYC_WR_BEGIN) || (kind == CYC_WR_CONT) ||
                   (kind == CYC_WR_SUSP);
  assign rd_cyc  = (kind == CYC_RD_BEGIN) || (kind == CYC_RD_CONT) ||
                   (kind == CYC_RD_SUSP);
  assign lane_wr = wr_cyc ? lane_mask(wr_all_n, byte_wr_n, lane_en_n) : '0;
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_t          kind,
  input  src_t          src,
  input  logic          linear_mode,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] eff_addr,
  output logic          live
);
  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  logic [1:0]    step_sel;

  always_comb begin
    step_sel = step_q;
    if (src == SRC_NEXT) step_sel = step_q + 2'd1;
  end

  always_comb begin
    if (src == SRC_EXT) eff_addr = ext_addr;
    else eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], step_sel, linear_mode)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      live   <= 1'b0;
    end else begin
      case (kind)
        CYC_RD_BEGIN, CYC_WR_BEGIN: begin
          base_q <= ext_addr;
          step_q <= '0;
          live   <= 1'b1;
        end
        CYC_RD_CONT, CYC_WR_CONT: step_q <= step_sel;
        CYC_DESEL: live <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_cyc,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_valid
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_wr[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_cyc) rdata[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else rd_valid <= rd_cyc;
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    burst_step_n,
  input  logic                    wr_all_n,
  input  logic                    byte_wr_n,
  input  logic [3:0]              lane_en_n,
  input  logic                    sleep,
  input  logic                    out_en_n,
  input  logic                    linear_mode,
  input  logic [AW-1:0]           addr,
  input  logic [4*LANE_W-1:0]     wdata,
  output logic [4*LANE_W-1:0]     dq_out,
  output logic                    dq_oe,
  output logic [2:0]              cyc_kind,
  output logic [1:0]              addr_src,
  output logic [3:0]              lane_wr
);
  localparam int DW = LANES * LANE_W;

  cyc_t          kind;
  src_t          src;
  logic          rd_cyc, wr_cyc, live;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] rdata;
  logic          rd_valid;

  bsram_decode u_dec (
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .burst_step_n(burst_step_n),
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
    .sleep(sleep), .burst_live(live),
    .kind(kind), .src(src), .lane_wr(lane_wr), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc)
  );

  bsram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .kind(kind), .src(src),
    .linear_mode(linear_mode), .ext_addr(addr),
    .eff_addr(eff_addr), .live(live)
  );

  bsram_array #(.AW(AW), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .addr(eff_addr), .lane_wr(lane_wr),
    .wdata(wdata), .rd_cyc(rd_cyc), .rdata(rdata), .rd_valid(rd_valid)
  );

  assign dq_oe    = rd_valid && !out_en_n && !sleep;
  assign dq_out   = dq_oe ? rdata : '0;
  assign cyc_kind = kind;
  assign addr_src = src;
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker
  import bsram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sel1_n,
  input logic       sel2,
  input logic       sel3_n,
  input logic       cpu_stb_n,
  input logic       ctl_stb_n,
  input logic       wr_all_n,
  input logic       sleep,
  input logic       out_en_n,
  input logic       wr_cyc,
  input logic       dq_oe,
  input logic [2:0] cyc_kind,
  input logic [1:0] addr_src,
  input logic [3:0] lane_wr
);
  logic chip_on;
  assign chip_on = !sel1_n && sel2 && !sel3_n;

  AST_CPU_STB_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && !cpu_stb_n && !sleep) |->
      (cyc_kind == 3'd1 && addr_src == 2'd1 && lane_wr == 4'd0)); // R1
  AST_SEL1_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_n && !ctl_stb_n && !sleep) |-> (cyc_kind == 3'd0 && addr_src == 2'd0)); // R2
  AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && !wr_all_n) |-> (lane_wr == 4'hF)); // R4
  AST_SUSP_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd5 || cyc_kind == 3'd6) |-> (addr_src == 2'd3)); // R5
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe); // R10
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (cyc_kind == 3'd7 && addr_src == 2'd0 && lane_wr == 4'd0 && !dq_oe)); // R11
  AST_NO_DRIVE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr != 4'd0) |=> !dq_oe); // R12
endmodule

bind burst_sram_ctrl bsram_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
  .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .wr_all_n(wr_all_n),
  .sleep(sleep), .out_en_n(out_en_n), .wr_cyc(wr_cyc), .dq_oe(dq_oe),
  .cyc_kind(cyc_kind), .addr_src(addr_src), .lane_wr(lane_wr)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctrl_bench;
  localparam int AW = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
  logic cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, burst_step_n = 1'b1;
  logic wr_all_n = 1'b1, byte_wr_n = 1'b1, sleep = 1'b0, out_en_n = 1'b0;
  logic linear_mode = 1'b1;
  logic [3:0] lane_en_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] dq_out;
  logic dq_oe;
  logic [2:0] cyc_kind;
  logic [1:0] addr_src;
  logic [3:0] lane_wr;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] ref_mem [64];

  always #10 clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .LANE_W(8)) u_burst_sram_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic idle;
    sel1_n = 1'b1; sel2 = 1'b1; sel3_n = 1'b0;
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; burst_step_n = 1'b1;
    wr_all_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 4'hF;
    sleep = 1'b0; out_en_n = 1'b0;
  endtask

  function automatic logic [5:0] baddr(logic [5:0] s, logic [1:0] k, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(s[1:0] + k) : {s[1] ^ k[1], s[0] ^ k[0]};
    return {s[5:2], lo};
  endfunction

  // begin a read on the controller strobe, then check the data after the edge
  task automatic ctl_read_start(logic [5:0] a, logic lin);
    idle(); sel1_n = 1'b0; ctl_stb_n = 1'b0; addr = a; linear_mode = lin;
    #1 chk("R3 read begin kind", 32'(cyc_kind), 32'd1);
    tick();
    chk("R9 first read data", dq_out, ref_mem[a]);
  endtask

  task automatic t_reset;
    chk("R12 reset no drive", 32'(dq_oe), 32'd0);
    chk("R7 idle after reset", 32'(cyc_kind), 32'd0);
    chk("R7 reset src none", 32'(addr_src), 32'd0);
  endtask

  task automatic t_write_burst_linear;
    idle(); sel1_n = 1'b0; ctl_stb_n = 1'b0; wr_all_n = 1'b0;
    addr = 6'd5; linear_mode = 1'b1; wdata = 32'h1111_0005;
    #1 chk("R3 write begin", 32'(cyc_kind), 32'd2);
    chk("R3 ext src", 32'(addr_src), 32'd1);
    chk("R4 all lanes", 32'(lane_wr), 32'hF);
    tick(); ref_mem[5] = wdata;
    chk("R12 no drive after write", 32'(dq_oe), 32'd0);
    ctl_stb_n = 1'b1; burst_step_n = 1'b0;
    for (int k = 1; k < 4; k++) begin
      wdata = 32'h2222_0000 + k;
      #1 chk("R5 write continue", 32'(cyc_kind), 32'd4);
      chk("R5 next src", 32'(addr_src), 32'd2);
      tick(); ref_mem[baddr(6'd5, 2'(k), 1'b1)] = wdata;
    end
  endtask

  task automatic t_read_interleaved;
    ctl_read_start(6'd5, 1'b0);
    chk("R9 drive on read", 32'(dq_oe), 32'd1);
    ctl_stb_n = 1'b1; burst_step_n = 1'b0;
    for (int k = 1; k < 4; k++) begin
      #1 chk("R5 read continue", 32'(cyc_kind), 32'd3);
      tick();
      chk("R6 interleaved order", dq_out, ref_mem[baddr(6'd5, 2'(k), 1'b0)]);
    end
  endtask

  task automatic t_byte_lanes;
    idle(); sel1_n = 1'b0; ctl_stb_n = 1'b0; byte_wr_n = 1'b0; lane_en_n = 4'hF;
    addr = 6'd5;
    #1 chk("R4 no lane picked is read", 32'(cyc_kind), 32'd1);
    chk("R4 no lane strobes", 32'(lane_wr), 32'd0);
    lane_en_n = 4'b1010; wdata = 32'hAABB_CCDD;
    #1 chk("R4 lane strobes", 32'(lane_wr), 32'b0101);
    tick();
    ref_mem[5] = {ref_mem[5][31:24], wdata[23:16], ref_mem[5][15:8], wdata[7:0]};
    ctl_read_start(6'd5, 1'b1);
    chk("R4 merged lanes", dq_out, 32'hAA00_CC00 & 32'h0 | ref_mem[5]);
  endtask

  task automatic t_cpu_forces_read;
    idle(); sel1_n = 1'b0; cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; wr_all_n = 1'b0;
    addr = 6'd5; wdata = 32'hDEAD_BEEF;
    #1 chk("R1 cpu strobe read", 32'(cyc_kind), 32'd1);
    chk("R1 no write", 32'(lane_wr), 32'd0);
    tick();
    chk("R1 array untouched", dq_out, ref_mem[5]);
  endtask

  task automatic t_write_on_wait;
    idle(); sel1_n = 1'b0; cpu_stb_n = 1'b0; addr = 6'd12;
    tick();
    cpu_stb_n = 1'b1; burst_step_n = 1'b1; wr_all_n = 1'b0; wdata = 32'h0C0C_1212;
    #1 chk("R8 wait write kind", 32'(cyc_kind), 32'd6);
    chk("R8 current src", 32'(addr_src), 32'd3);
    tick(); ref_mem[12] = wdata;
    chk("R12 write hides data", 32'(dq_oe), 32'd0);
    ctl_read_start(6'd12, 1'b1);
    chk("R8 written at read addr", dq_out, 32'h0C0C_1212);
  endtask

  task automatic t_suspend;
    ctl_read_start(6'd4, 1'b1);
    ctl_stb_n = 1'b1; burst_step_n = 1'b1;
    #1 chk("R5 read suspend", 32'(cyc_kind), 32'd5);
    tick();
    chk("R5 suspend holds addr", dq_out, ref_mem[4]);
    burst_step_n = 1'b0;
    tick();
    chk("R6 linear next", dq_out, ref_mem[5]);
  endtask

  task automatic t_deselect;
    ctl_read_start(6'd4, 1'b1);
    sel1_n = 1'b1; ctl_stb_n = 1'b1; cpu_stb_n = 1'b0; burst_step_n = 1'b0;
    #1 chk("R2 cpu ignored, burst continues", 32'(cyc_kind), 32'd3);
    tick();
    chk("R2 continued data", dq_out, ref_mem[5]);
    ctl_stb_n = 1'b0;
    #1 chk("R2 sel1 high deselects", 32'(cyc_kind), 32'd0);
    chk("R2 no src", 32'(addr_src), 32'd0);
    tick();
    chk("R7 no drive after deselect", 32'(dq_oe), 32'd0);
    ctl_stb_n = 1'b1;
    #1 chk("R7 dead burst", 32'(cyc_kind), 32'd0);
    sel1_n = 1'b0; sel3_n = 1'b1;
    #1 chk("R2 sel3 deselects", 32'(cyc_kind), 32'd0);
    sel3_n = 1'b0; sel2 = 1'b0;
    #1 chk("R2 sel2 deselects", 32'(cyc_kind), 32'd0);
    tick();
  endtask

  task automatic t_out_enable;
    ctl_read_start(6'd6, 1'b1);
    out_en_n = 1'b1;
    #1 chk("R10 oe off async", 32'(dq_oe), 32'd0);
    chk("R10 data zero", dq_out, 32'd0);
    out_en_n = 1'b0;
    #1 chk("R10 oe on async", 32'(dq_oe), 32'd1);
    chk("R10 data back", dq_out, ref_mem[6]);
  endtask

  task automatic t_sleep;
    ctl_read_start(6'd4, 1'b1);
    ctl_stb_n = 1'b1; burst_step_n = 1'b0;
    tick();
    sleep = 1'b1; wr_all_n = 1'b0; wdata = 32'hFFFF_FFFF;
    #1 chk("R11 sleep kind", 32'(cyc_kind), 32'd7);
    chk("R11 sleep src", 32'(addr_src), 32'd0);
    chk("R11 sleep lanes", 32'(lane_wr), 32'd0);
    chk("R11 sleep hi-z", 32'(dq_oe), 32'd0);
    tick();
    chk("R11 still hi-z", 32'(dq_oe), 32'd0);
    sleep = 1'b0; wr_all_n = 1'b1;
    #1 chk("R11 burst resumes", 32'(cyc_kind), 32'd3);
    tick();
    chk("R11 position held, no write", dq_out, ref_mem[6]);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_burst_linear();
    t_read_interleaved();
    t_byte_lanes();
    t_cpu_forces_read();
    t_write_on_wait();
    t_suspend();
    t_deselect();
    t_out_enable();
    t_sleep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule